// File: doc/BRIEF.md
# Windowed Scalar Register-Field Decoder

This block turns the scalar operand fields of a 128-bit instruction bundle into physical register numbers. A selector picks one of two operand slots. The first is the load/store slot, which starts at bundle bit 4. The second is the load slot, which starts at bundle bit 16. Each operand field is four bits wide: a three-bit low index and one bank bit. The bank bit is inverted on its way to index bit 3. When windowed addressing is on, eight times the window base is added to the field, and the sum wraps to 64 physical registers.

A second operand form replaces source 2 with a sign-extended 8-bit immediate. The destination and source-1 fields are still decoded as usual in that form. The low nibble of the bundle is the format selector, and no operand bit is taken from it. All results are captured into output registers on an input strobe, and a valid flag follows one cycle later. The block reads no register file and performs no operation on operand values.

Top module: `wsrd_decoder`

## Requirements
- R1: Bundle bits [3:0] never change any output.
- R2: With `slot_sel` = 0, the destination field comes from bits 14:12 with bank bit 15. Source 1 comes from bits 10:8 with bank bit 11. Source 2 comes from bits 6:4 with bank bit 7.
- R3: Each field value is low3 + 8 × (inverted bank bit). A bank bit of 1 in the bundle therefore gives an index below 8.
- R4: With `win_en` = 1, each index is (field + 8 × `win_base`) mod 64.
- R5: With `win_en` = 0, each index equals the 4-bit field, zero-extended to 6 bits, and `win_base` has no effect.
- R6: With `slot_sel` = 1, the destination field comes from bits 62:60 with bank bit 63. Source 1 comes from bits 18:16 with bank bit 19. Source 2 comes from bits 22:20 with bank bit 23.
- R7: With `imm_form` = 1, `src2_val` is bundle bits 23:16 sign-extended to 32 bits, giving a range of −128..127, in either slot. The destination is still decoded.
- R8: With `imm_form` = 0, `src2_val` holds the source-2 index zero-extended to 32 bits.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. The outputs then show the operands of the strobed bundle.
- R10: Without a strobe, `dst_idx`, `src1_idx` and `src2_val` keep their values.
- R11: While `rst` is high, `out_valid` and all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the current bundle |
| bundle | input | 128 | Instruction bundle |
| slot_sel | input | 1 | 0 = load/store slot, 1 = load slot |
| win_en | input | 1 | Windowed register addressing enable |
| win_base | input | 4 | Window base, in units of 8 registers |
| imm_form | input | 1 | 1 = source 2 is the sign-extended immediate |
| out_valid | output | 1 | Registered results are valid |
| dst_idx | output | 6 | Destination physical register index |
| src1_idx | output | 6 | Source-1 physical register index |
| src2_val | output | 32 | Source-2 index (zero-extended) or immediate |

## Verification
Two functions can act on the same field in the same cycle: the inverted bank bit and the window-base addition. Together they can push the sum past 63, so it has to wrap. The bench provokes this by sweeping every 4-bit field value against every window base, in both slots and both windowing modes. Each operand role gets a different field value, so that swapped fields would show. Every resulting index is judged against (field + 8 × base) mod 64, which the bench computes directly from the field value it placed in the bundle.

// File: rtl/wsrd_pkg.sv
package wsrd_pkg;
  localparam int NSLOT    = 2;
  localparam int NROLE    = 3;
  localparam int FLD_W    = 4;
  localparam int ROLE_DST = 0;
  localparam int ROLE_S1  = 1;
  localparam int ROLE_S2  = 2;
  localparam int IMM_LSB  = 16;
  localparam int IMM_W    = 8;
  localparam int STEP_LG  = 3;

  // low bit of each operand field; the bank bit sits three above it
  function automatic int field_lsb(int slot, int role);
    int p;
    p = 0;
    if (slot == 0) begin
      case (role)
        ROLE_DST: p = 12;
        ROLE_S1:  p = 8;
        default:  p = 4;
      endcase
    end else begin
      case (role)
        ROLE_DST: p = 60;
        ROLE_S1:  p = 16;
        default:  p = 20;
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/wsrd_field_pick.sv
module wsrd_field_pick #(
  parameter int FLD_W = 4
) (
  input  logic [FLD_W-1:0] raw,
  output logic [FLD_W-1:0] fld
);
  always_comb begin
    fld = raw;
    fld[FLD_W-1] = ~raw[FLD_W-1];
  end
endmodule

// File: rtl/wsrd_win_add.sv
module wsrd_win_add #(
  parameter int FLD_W   = 4,
  parameter int WB_W    = 4,
  parameter int PIDX_W  = 6,
  parameter int STEP_LG = 3
) (
  input  logic [FLD_W-1:0]  fld,
  input  logic              win_en,
  input  logic [WB_W-1:0]   win_base,
  output logic [PIDX_W-1:0] idx
);
  localparam int SCALED_W = WB_W + STEP_LG;
  logic [SCALED_W-1:0] scaled;
  logic [PIDX_W-1:0]   offset;

  always_comb begin
    scaled = {win_base, {STEP_LG{1'b0}}};
    offset = win_en ? PIDX_W'(scaled) : '0;
    idx    = PIDX_W'(fld) + offset;
  end
endmodule

// File: rtl/wsrd_imm_ext.sv
module wsrd_imm_ext #(
  parameter int IMM_W = 8,
  parameter int OUT_W = 32
) (
  input  logic [IMM_W-1:0] imm,
  output logic [OUT_W-1:0] value
);
  assign value = {{(OUT_W-IMM_W){imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/wsrd_decoder.sv
module wsrd_decoder #(
  parameter int BUNDLE_W = 128,
  parameter int WB_W     = 4,
  parameter int OPW      = 32,
  parameter int PIDX_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BUNDLE_W-1:0] bundle,
  input  logic                slot_sel,
  input  logic                win_en,
  input  logic [WB_W-1:0]     win_base,
  input  logic                imm_form,
  output logic                out_valid,
  output logic [PIDX_W-1:0]   dst_idx,
  output logic [PIDX_W-1:0]   src1_idx,
  output logic [OPW-1:0]      src2_val
);
  import wsrd_pkg::*;

  localparam int ZPAD = OPW - PIDX_W;

  logic [FLD_W-1:0]  fld     [NSLOT][NROLE];
  logic [FLD_W-1:0]  sel_fld [NROLE];
  logic [PIDX_W-1:0] idx     [NROLE];
  logic [OPW-1:0]    imm_val;
  logic [OPW-1:0]    src2_next;
  logic              unused_bits;

  assign unused_bits = ^bundle;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar r = 0; r < NROLE; r++) begin : g_role
      localparam int LSB = field_lsb(s, r);
      wsrd_field_pick #(.FLD_W(FLD_W)) u_pick (
        .raw (bundle[LSB +: FLD_W]),
        .fld (fld[s][r])
      );
    end
  end

  for (genvar r = 0; r < NROLE; r++) begin : g_win
    assign sel_fld[r] = fld[slot_sel][r];
    wsrd_win_add #(
      .FLD_W(FLD_W), .WB_W(WB_W), .PIDX_W(PIDX_W), .STEP_LG(STEP_LG)
    ) u_add (
      .fld      (sel_fld[r]),
      .win_en   (win_en),
      .win_base (win_base),
      .idx      (idx[r])
    );
  end

  wsrd_imm_ext #(.IMM_W(IMM_W), .OUT_W(OPW)) u_imm (
    .imm   (bundle[IMM_LSB +: IMM_W]),
    .value (imm_val)
  );

  assign src2_next = imm_form ? imm_val : {{ZPAD{1'b0}}, idx[ROLE_S2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_idx   <= '0;
      src1_idx  <= '0;
      src2_val  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_idx  <= idx[ROLE_DST];
        src1_idx <= idx[ROLE_S1];
        src2_val <= src2_next;
      end
    end
  end

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dst_idx) && $stable(src1_idx) && $stable(src2_val)));

  // R5
  flat_window_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !win_en) |=>
      (dst_idx[PIDX_W-1:FLD_W] == '0 && src1_idx[PIDX_W-1:FLD_W] == '0));

  // R7
  imm_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && imm_form) |=>
      (src2_val[OPW-1:IMM_W-1] == '0 || src2_val[OPW-1:IMM_W-1] == '1));

  // R8
  reg_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !imm_form) |=> (src2_val[OPW-1:PIDX_W] == '0));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && dst_idx == '0 && src1_idx == '0 && src2_val == '0));
endmodule

// File: tb/wsrd_decoder_test.sv
`timescale 1ns/1ps
module wsrd_decoder_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] bundle;
  logic         slot_sel;
  logic         win_en;
  logic [3:0]   win_base;
  logic         imm_form;
  logic         out_valid;
  logic [5:0]   dst_idx;
  logic [5:0]   src1_idx;
  logic [31:0]  src2_val;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wsrd_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .bundle(bundle),
    .slot_sel(slot_sel), .win_en(win_en), .win_base(win_base),
    .imm_form(imm_form), .out_valid(out_valid), .dst_idx(dst_idx),
    .src1_idx(src1_idx), .src2_val(src2_val)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lsb_of(int slot, int role);
    if (slot == 0) return (role == 0) ? 12 : (role == 1) ? 8 : 4;
    return (role == 0) ? 60 : (role == 1) ? 16 : 20;
  endfunction

  // place field value v (0..15) so that low3 = v[2:0], raw bank = ~v[3]
  function automatic logic [127:0] place(logic [127:0] b, int lsb, int v);
    logic [127:0] r;
    r = b;
    r[lsb]   = v[0];
    r[lsb+1] = v[1];
    r[lsb+2] = v[2];
    r[lsb+3] = ~v[3];
    return r;
  endfunction

  function automatic logic [31:0] expect_idx(int v, bit en, int base);
    return en ? 32'((v + 8 * base) % 64) : 32'(v);
  endfunction

  task automatic apply(logic [127:0] b, bit s, bit en, int base, bit im);
    @(negedge clk);
    bundle = b; slot_sel = s; win_en = en; win_base = 4'(base); imm_form = im;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; bundle = '1; slot_sel = 1'b0;
    win_en = 1'b0; win_base = '0; imm_form = 1'b0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", 32'(out_valid), 0);
    chk("R11 dst", 32'(dst_idx), 0);
    chk("R11 src2", src2_val, 0);
    in_valid = 1'b0;
    rst = 1'b0;

    // R2/R6 with R4/R5: all fields x all bases, both slots and modes
    for (int s = 0; s < 2; s++)
      for (int en = 0; en < 2; en++)
        for (int base = 0; base < 16; base++)
          for (int v = 0; v < 16; v++) begin
            logic [127:0] b;
            int vd, v1, v2;
            vd = v; v1 = (v + 5) % 16; v2 = (v + 11) % 16;
            b = {$urandom, $urandom, $urandom, $urandom};
            b = place(b, lsb_of(s, 0), vd);
            b = place(b, lsb_of(s, 1), v1);
            b = place(b, lsb_of(s, 2), v2);
            apply(b, s[0], en[0], base, 1'b0);
            chk(en ? "R4 dst" : "R5 dst", 32'(dst_idx), expect_idx(vd, en[0], base));
            chk(en ? "R4 src1" : "R5 src1", 32'(src1_idx), expect_idx(v1, en[0], base));
            chk(s ? "R6 src2" : "R2 src2", src2_val, expect_idx(v2, en[0], base));
            if (v == 0 && base == 0) chk("R8 zext", src2_val >> 6, 0);
            if (v == 3 && base == 0) chk("R9 valid", 32'(out_valid), 1);
          end

    // R3 bank bit of 1 in the bundle yields low index, 0 yields +8
    begin
      logic [127:0] b;
      b = '0;
      b[14:12] = 3'd5; b[15] = 1'b1;
      b[10:8]  = 3'd2; b[11] = 1'b0;
      apply(b, 1'b0, 1'b0, 0, 1'b0);
      chk("R3 bank set", 32'(dst_idx), 5);
      chk("R3 bank clear", 32'(src1_idx), 10);
    end

    // R1 selector nibble has no effect
    for (int n = 0; n < 16; n++) begin
      logic [127:0] b;
      b = place(128'h0, 12, 9);
      b = place(b, 8, 6);
      b = place(b, 4, 14);
      b[3:0] = 4'(n);
      apply(b, 1'b0, 1'b1, 7, 1'b0);
      chk("R1 dst", 32'(dst_idx), expect_idx(9, 1'b1, 7));
      chk("R1 src2", src2_val, expect_idx(14, 1'b1, 7));
    end

    // R7 immediate form, every 8-bit value in both slots
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 256; x++) begin
        logic [127:0] b;
        logic [7:0] x8;
        x8 = 8'(x);
        b = {$urandom, $urandom, $urandom, $urandom};
        b = place(b, lsb_of(s, 0), x % 16);
        b[23:16] = x8;
        apply(b, s[0], 1'b1, 3, 1'b1);
        chk("R7 imm", src2_val, {{24{x8[7]}}, x8});
        chk("R7 dst", 32'(dst_idx), expect_idx(x % 16, 1'b1, 3));
      end

    // R9 valid drops and R10 outputs hold without a strobe
    begin
      logic [5:0]  d0, s0;
      logic [31:0] v0;
      apply(place(128'h0, 12, 11), 1'b0, 1'b1, 2, 1'b0);
      d0 = dst_idx; s0 = src1_idx; v0 = src2_val;
      @(negedge clk);
      bundle = ~bundle; win_base = 4'd9; imm_form = 1'b1;
      chk("R9 valid low", 32'(out_valid), 0);
      @(negedge clk);
      @(negedge clk);
      chk("R10 dst hold", 32'(dst_idx), 32'(d0));
      chk("R10 src1 hold", 32'(src1_idx), 32'(s0));
      chk("R10 src2 hold", src2_val, v0);
    end

    finish_run();
  end
endmodule